// File: doc/BRIEF.md
# Dual-Direction Message Mailbox with Latching Status Events

This block lets an application processor and an I/O processor pass fixed-size messages to each other through two independent queues. One queue carries traffic toward the I/O processor (outbound). The other carries traffic back to the application processor (inbound). A message is 96 bits: a full 64-bit first word and a 32-bit payload carried in the low half of a second word. Both processors share one register map, reached through a plain 64-bit read/write register port that takes byte addresses.

A sender stages the first word and then writes the second word. Writing the second word pushes both words into the queue together. A receiver may read the first word of the head entry as often as it likes. Reading the second word returns the payload together with the queue's pointers and counters, and removes the entry. Four status events track the empty and not-empty state of both queues. Each event stays pending while its condition holds and also remembers that the condition held at any point since it was last acknowledged. One interrupt line reports the pending events that software has enabled.

Top module: `mbx_top`

## Requirements
- R1: Each queue has a control word: outbound at 0x50, inbound at 0x80. Bit 16 reads 1 when the queue is full and bit 17 reads 1 when it is empty. All other bits read 0.
- R2: Writing a first send word (outbound 0x60, inbound 0x90) only stages it and does not change the queue. Writing a second send word (outbound 0x68, inbound 0x98) pushes the staged word with bits 31:0 of the written data as one entry. Bits 63:32 of that write are dropped.
- R3: Each queue holds DEPTH entries (8 by default) in arrival order. Reading the first receive word (outbound 0x70, inbound 0xA0) returns the head's first word without removing it. Reading the second receive word (outbound 0x78, inbound 0xA8) removes the head.
- R4: A push into a full queue is ignored and leaves contents, pointers and level unchanged.
- R5: A read of the second receive word from an empty queue removes nothing and changes no state. The payload and first word then read as 0.
- R6: A read of the second receive word returns the payload in bits 31:0, the write index in 43:40, the read index in 47:44, the entry count in 51:48 and the running total of removed entries (modulo 32) in 56:52. All of these are taken before the removal. Other bits are 0.
- R7: Event bits are: bit 0 outbound empty, bit 1 outbound not-empty, bit 2 inbound empty, bit 3 inbound not-empty. An event is pending while its condition holds. Reading 0x4C returns the four pending bits.
- R8: An event stays pending after its condition ends, until a 1 is written to its bit at 0x4C. Writing 0 to a bit leaves that event unchanged.
- R9: Acknowledging an event whose condition still holds leaves it pending.
- R10: 0x48 holds a 4-bit enable mask and reads back in bits 3:0. The interrupt output is 1 exactly when some pending event is enabled.
- R11: After reset both queues are empty, the enables and latches are clear, and the interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; data appears after the edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data, held until the next read |
| irq | output | 1 | Level interrupt: enabled pending events |

## Verification
The bench builds the block with its default depth of 8. With that depth, one single-message exchange followed by eight more pushes fills the outbound queue and wraps its write index back to 1. Draining it then wraps the read index, so both wrap paths and the full-push refusal are reached in a few dozen cycles. The removed-entry total reaches 9, below its 5-bit wrap. The inbound queue is used to drive the sticky not-empty event through assert, drain, acknowledge-while-true and final clear.

// File: rtl/mbx_pkg.sv
// Package: shared constants for the mailbox register map and event bits.
// Assumes byte addressing with 8-bit addresses and 64-bit data words.
package mbx_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 64;
    localparam int PAY_W    = 32;
    localparam int MSG_W    = DATA_W + PAY_W;
    localparam int NUM_DIR  = 2;
    localparam int NUM_EVT  = 4;
    localparam int POPCNT_W = 5;
    localparam int FLD_W    = 4;

    // Control word flag positions
    localparam int CTRL_FULL_BIT  = 16;
    localparam int CTRL_EMPTY_BIT = 17;

    // Offsets of a queue's words from its control word
    localparam logic [ADDR_W-1:0] OFS_SEND0 = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SEND1 = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RECV0 = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RECV1 = 8'h28;

    localparam logic [ADDR_W-1:0] EVT_EN_ADDR  = 8'h48;
    localparam logic [ADDR_W-1:0] EVT_ACK_ADDR = 8'h4C;

    // Event bit indices
    localparam int EV_OUT_EMPTY  = 0;
    localparam int EV_OUT_NEMPTY = 1;
    localparam int EV_IN_EMPTY   = 2;
    localparam int EV_IN_NEMPTY  = 3;

    // Control-word address of a direction (0 outbound, 1 inbound)
    function automatic logic [ADDR_W-1:0] dir_base(input int d);
        return (d == 0) ? 8'h50 : 8'h80;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
// Module: mbx_fifo
// A synchronous queue of DEPTH entries with a head view, occupancy level,
// both indices and a running total of removals. Assumes push and pop are
// single-cycle strobes. A push into a full queue or a pop from an empty
// queue is dropped with no state change.
module mbx_fifo #(
    parameter  int WIDTH = 96,
    parameter  int DEPTH = 8,
    parameter  int CNT_W = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [LVL_W-1:0] level,
    output logic [CNT_W-1:0] pops
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] level_q;
    logic [CNT_W-1:0] pops_q;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] next_idx(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level_q == FULL_LVL);
    assign empty   = (level_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    // Store an accepted entry at the write index
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= wdata;
    end

    // Advance indices, level and removal total on accepted operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
            pops_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= next_idx(wptr_q);
            if (pop_ok) begin
                rptr_q <= next_idx(rptr_q);
                pops_q <= pops_q + 1'b1;
            end
            if (push_ok && !pop_ok)      level_q <= level_q + 1'b1;
            else if (pop_ok && !push_ok) level_q <= level_q - 1'b1;
        end
    end

    assign head  = mem[rptr_q];
    assign wptr  = wptr_q;
    assign rptr  = rptr_q;
    assign level = level_q;
    assign pops  = pops_q;

    // R4
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(level_q) && $stable(wptr_q)));

    // R5
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(rptr_q) && $stable(pops_q)));

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL_LVL);
endmodule

// File: rtl/mbx_dir.sv
// Module: mbx_dir
// One direction of the mailbox: a staging register for the first send word,
// the queue, and formatting of both receive words. Assumes the decoder
// gives single-cycle write and pop strobes. Commit happens on the write of
// the second send word.
module mbx_dir
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_first,
    input  logic              wr_second,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] recv_first,
    output logic [DATA_W-1:0] recv_second,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0]   stage_q;
    logic [MSG_W-1:0]    entry;
    logic [PTR_W-1:0]    wptr, rptr;
    logic [LVL_W-1:0]    level;
    logic [POPCNT_W-1:0] pops;

    // Hold the staged first word until the commit write
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (wr_first) stage_q <= wdata;
    end

    mbx_fifo #(
        .WIDTH (MSG_W),
        .DEPTH (DEPTH),
        .CNT_W (POPCNT_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_second),
        .pop   (pop),
        .wdata ({stage_q, wdata[PAY_W-1:0]}),
        .head  (entry),
        .full  (full),
        .empty (empty),
        .wptr  (wptr),
        .rptr  (rptr),
        .level (level),
        .pops  (pops)
    );

    // Present the head words; an empty queue shows zero data
    always_comb begin
        recv_first  = empty ? '0 : entry[MSG_W-1:PAY_W];
        recv_second = {7'b0, pops, FLD_W'(level), FLD_W'(rptr), FLD_W'(wptr),
                       8'b0, (empty ? {PAY_W{1'b0}} : entry[PAY_W-1:0])};
    end

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}));
endmodule

// File: rtl/mbx_evt.sv
// Module: mbx_evt
// Latching status events and interrupt. Each event is pending while its
// condition holds or if the condition held at any edge since its last
// acknowledge. Assumes ack and enable writes are single-cycle strobes.
module mbx_evt
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] cond,
    input  logic               ack_wr,
    input  logic               en_wr,
    input  logic [NUM_EVT-1:0] wbits,
    output logic [NUM_EVT-1:0] pending,
    output logic [NUM_EVT-1:0] enable,
    output logic               irq
);
    logic [NUM_EVT-1:0] latch_q, en_q, ack_mask;

    assign ack_mask = ack_wr ? wbits : '0;

    // Remember conditions until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~ack_mask) | cond;
    end

    // Hold the enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wbits;
    end

    assign pending = latch_q | cond;
    assign enable  = en_q;
    assign irq     = |(pending & en_q);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt_chk
        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[i] && !ack_mask[i]) |=> pending[i]);
        // R9
        reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> pending[i]);
    end

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0));
endmodule

// File: rtl/mbx_top.sv
// Module: mbx_top
// Mailbox top: decodes the shared register map, instantiates the outbound
// and inbound directions and the event block, and registers read data.
// Assumes at most one of bus_wr and bus_rd per cycle; unmapped reads give 0.
module mbx_top
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NUM_DIR-1:0] wr_first, wr_second, pop, full, empty;
    logic [DATA_W-1:0]  recv_first  [NUM_DIR];
    logic [DATA_W-1:0]  recv_second [NUM_DIR];
    logic [NUM_EVT-1:0] cond, pending, enable;
    logic [DATA_W-1:0]  rd_mux, rdata_q;
    logic               ack_wr, en_wr;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam logic [ADDR_W-1:0] BASE = dir_base(d);

        assign wr_first[d]  = bus_wr && (bus_addr == BASE + OFS_SEND0);
        assign wr_second[d] = bus_wr && (bus_addr == BASE + OFS_SEND1);
        assign pop[d]       = bus_rd && (bus_addr == BASE + OFS_RECV1);

        mbx_dir #(
            .DEPTH (DEPTH)
        ) u_dir (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_first    (wr_first[d]),
            .wr_second   (wr_second[d]),
            .wdata       (bus_wdata),
            .pop         (pop[d]),
            .recv_first  (recv_first[d]),
            .recv_second (recv_second[d]),
            .full        (full[d]),
            .empty       (empty[d])
        );
    end

    assign cond[EV_OUT_EMPTY]  = empty[0];
    assign cond[EV_OUT_NEMPTY] = !empty[0];
    assign cond[EV_IN_EMPTY]   = empty[1];
    assign cond[EV_IN_NEMPTY]  = !empty[1];

    assign ack_wr = bus_wr && (bus_addr == EVT_ACK_ADDR);
    assign en_wr  = bus_wr && (bus_addr == EVT_EN_ADDR);

    mbx_evt u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond),
        .ack_wr  (ack_wr),
        .en_wr   (en_wr),
        .wbits   (bus_wdata[NUM_EVT-1:0]),
        .pending (pending),
        .enable  (enable),
        .irq     (irq)
    );

    // Select the addressed register for a read
    always_comb begin
        rd_mux = '0;
        if (bus_addr == EVT_EN_ADDR)  rd_mux = DATA_W'(enable);
        if (bus_addr == EVT_ACK_ADDR) rd_mux = DATA_W'(pending);
        for (int d = 0; d < NUM_DIR; d++) begin
            if (bus_addr == dir_base(d)) begin
                rd_mux[CTRL_FULL_BIT]  = full[d];
                rd_mux[CTRL_EMPTY_BIT] = empty[d];
            end
            if (bus_addr == dir_base(d) + OFS_RECV0) rd_mux = recv_first[d];
            if (bus_addr == dir_base(d) + OFS_RECV1) rd_mux = recv_second[d];
        end
    end

    // Capture read data on a read strobe and hold it
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R2
    stage_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == dir_base(0) + OFS_SEND0)) |=> $stable(empty[0]));
endmodule

// File: tb/tb_mbx_top.sv
// Directed bench for mbx_top: one task per scenario, each checking results.
module tb_mbx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    mbx_top #(.DEPTH(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [63:0] fld(input int pc, input int lv, input int rp,
                                        input int wp, input logic [31:0] p);
        return (64'(pc) << 52) | (64'(lv) << 48) | (64'(rp) << 44) | (64'(wp) << 40) | 64'(p);
    endfunction

    task automatic t_reset();
        logic [63:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq after reset", 64'(irq), 64'd0);
        rd(8'h50, d); chk("R1 R11 outbound ctrl empty", d, 64'h20000);
        rd(8'h80, d); chk("R1 R11 inbound ctrl empty", d, 64'h20000);
        rd(8'h4C, d); chk("R7 R11 pending after reset", d, 64'h5);
        rd(8'h48, d); chk("R11 enables cleared", d, 64'h0);
    endtask

    task automatic t_single();
        logic [63:0] d;
        wr(8'h60, 64'h1122334455667788);
        rd(8'h50, d); chk("R2 staging does not push", d, 64'h20000);
        wr(8'h68, 64'hFFFFFFFF_CAFEF00D);
        rd(8'h50, d); chk("R1 not full not empty", d, 64'h0);
        rd(8'h70, d); chk("R3 first word", d, 64'h1122334455667788);
        rd(8'h70, d); chk("R3 first word read does not pop", d, 64'h1122334455667788);
        rd(8'h78, d); chk("R6 R2 second word fields", d, fld(0, 1, 0, 1, 32'hCAFEF00D));
        rd(8'h50, d); chk("R3 popped to empty", d, 64'h20000);
        rd(8'h4C, d); chk("R8 not-empty latched after drain", d, 64'h7);
        wr(8'h4C, 64'h2);
        rd(8'h4C, d); chk("R8 ack clears latch", d, 64'h5);
    endtask

    task automatic t_fill();
        logic [63:0] d;
        for (int i = 0; i < 8; i++) begin
            wr(8'h60, 64'hA0 + 64'(i));
            wr(8'h68, 64'h100 + 64'(i));
        end
        rd(8'h50, d); chk("R1 full flag", d, 64'h10000);
        wr(8'h60, 64'hDEAD);
        wr(8'h68, 64'hBEEF);
        rd(8'h50, d); chk("R4 still full after refused push", d, 64'h10000);
        for (int i = 0; i < 8; i++) begin
            rd(8'h70, d); chk("R3 R4 order first word", d, 64'hA0 + 64'(i));
            rd(8'h78, d); chk("R6 R4 order second word", d,
                              fld(1 + i, 8 - i, (1 + i) % 8, 1, 32'h100 + 32'(i)));
        end
        rd(8'h50, d); chk("R4 drained after eight", d, 64'h20000);
    endtask

    task automatic t_empty_pop();
        logic [63:0] d;
        rd(8'h78, d); chk("R5 empty pop fields", d, fld(9, 0, 1, 1, 32'h0));
        rd(8'h78, d); chk("R5 empty pop leaves state", d, fld(9, 0, 1, 1, 32'h0));
        rd(8'h70, d); chk("R5 empty first word zero", d, 64'h0);
    endtask

    task automatic t_irq();
        logic [63:0] d;
        wr(8'h48, 64'h8);
        rd(8'h48, d); chk("R10 enable readback", d, 64'h8);
        wr(8'h4C, 64'hF);
        chk("R10 irq low with masked pending", 64'(irq), 64'd0);
        wr(8'h90, 64'h0123456789ABCDEF);
        wr(8'h98, 64'h5A5A5A5A);
        chk("R10 irq on inbound not-empty", 64'(irq), 64'd1);
        rd(8'h4C, d); chk("R7 pending set", d, 64'hD);
        wr(8'h4C, 64'h8);
        chk("R9 irq stays while condition true", 64'(irq), 64'd1);
        rd(8'h4C, d); chk("R9 pending after ack while true", d, 64'hD);
        rd(8'hA0, d); chk("R3 inbound first word", d, 64'h0123456789ABCDEF);
        rd(8'hA8, d); chk("R6 inbound second word", d, fld(0, 1, 0, 1, 32'h5A5A5A5A));
        chk("R8 irq sticky after drain", 64'(irq), 64'd1);
        wr(8'h4C, 64'h0);
        chk("R8 zero ack has no effect", 64'(irq), 64'd1);
        wr(8'h4C, 64'h8);
        chk("R8 irq clears on ack", 64'(irq), 64'd0);
        rd(8'h4C, d); chk("R7 R8 pending after clear", d, 64'h5);
        wr(8'h48, 64'h9);
        chk("R10 irq from outbound empty", 64'(irq), 64'd1);
        wr(8'h48, 64'h0);
        chk("R10 irq off with no enables", 64'(irq), 64'd0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_fill();
        t_empty_pop();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule